// File: doc/BRIEF.md
# Up-Down Counter with Preset

This block is a binary counter whose direction comes from two separate request pins. One pin asks for a step upward and the other asks for a step downward. When exactly one of them is high at a rising clock edge, the count moves by one in that direction. When the two pins agree, either both low or both high, the count keeps its value.

The count wraps around at both ends of its range. An active-low preset input works without the clock. While it is low it holds every bit of the count at one, and clock edges have no effect. The first rising edge after preset goes high again resumes normal operation.

The count is a plain status output with no handshake. The direction pins are plain control inputs, sampled on the rising edge.

Top module: `updn_counter`

## Requirements
- R1: The count output is 6 bits wide with default parameters (WIDTH = 6), so the largest value is 63.
- R2: With up_i = 1 and down_i = 0 at a rising clock edge, count_o becomes its previous value plus one after that edge.
- R3: With up_i = 0 and down_i = 1 at a rising clock edge, count_o becomes its previous value minus one after that edge.
- R4: With up_i = 0 and down_i = 0, count_o keeps its value across clock edges.
- R5: With up_i = 1 and down_i = 1, count_o keeps its value across clock edges.
- R6: Driving preset_n_i low sets every bit of count_o to 1 at once, without waiting for a clock edge.
- R7: While preset_n_i is low, clock edges do not change count_o, whatever the direction pins request. Counting resumes on the first rising edge after preset_n_i returns high.
- R8: A step up from the all-ones value (63) gives 0.
- R9: A step down from 0 gives the all-ones value (63).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the count updates on its rising edge |
| preset_n_i | input | 1 | Asynchronous active-low preset to all ones |
| up_i | input | 1 | Request to count up |
| down_i | input | 1 | Request to count down |
| count_o | output | WIDTH | Current count value |

## Verification
On every cycle outside preset, the assertions check the relation between the direction pins and the next count. They check the increment and decrement, holding when the pins agree, and both wrap points. They also check that the count reads all ones on every edge while preset is low.

Some behaviour only the bench scenarios can show. The count must change the moment preset falls, before any clock edge arrives. The count must also resume on the first edge after preset is released. Beyond these, the bench confirms concrete values along fixed sequences: down three steps from the preset value, then up three steps back.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Decoded action for one clock edge
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_INC  = 2'b01,
    STEP_DEC  = 2'b10
  } step_e;

endpackage

// File: rtl/updn_step_decode.sv
module updn_step_decode
  import updn_pkg::*;
(
  input  logic  up_i,
  input  logic  down_i,
  output step_e step_o
);

  always_comb begin
    unique case ({up_i, down_i})
      2'b10:   step_o = STEP_INC;
      2'b01:   step_o = STEP_DEC;
      default: step_o = STEP_HOLD;
    endcase
  end

endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg
  import updn_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             preset_n_i,
  input  step_e            step_i,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] delta;
  logic [WIDTH-1:0] count_next;

  // One adder serves both directions: +1 or +all-ones (i.e. -1)
  always_comb begin
    unique case (step_i)
      STEP_INC: delta = ONE;
      STEP_DEC: delta = ALL_ONES;
      default:  delta = '0;
    endcase
    count_next = count_o + delta;
  end

  always_ff @(posedge clk_i or negedge preset_n_i) begin
    if (!preset_n_i) count_o <= ALL_ONES;
    else             count_o <= count_next;
  end

  // R7
  preset_hold_chk: assert property (@(posedge clk_i)
    !preset_n_i |-> (count_o == ALL_ONES));

endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             preset_n_i,
  input  logic             up_i,
  input  logic             down_i,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  step_e step;

  updn_step_decode u_decode (
    .up_i   (up_i),
    .down_i (down_i),
    .step_o (step)
  );

  updn_count_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i      (clk_i),
    .preset_n_i (preset_n_i),
    .step_i     (step),
    .count_o    (count_o)
  );

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!preset_n_i)
    (up_i && !down_i) |=> (count_o == $past(count_o) + 1'b1));

  // R3
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!preset_n_i)
    (!up_i && down_i) |=> (count_o == $past(count_o) - 1'b1));

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!preset_n_i)
    (!up_i && !down_i) |=> $stable(count_o));

  // R5
  both_hold_chk: assert property (@(posedge clk_i) disable iff (!preset_n_i)
    (up_i && down_i) |=> $stable(count_o));

  // R8
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!preset_n_i)
    (up_i && !down_i && count_o == MAX_VAL) |=> (count_o == '0));

  // R9
  wrap_down_chk: assert property (@(posedge clk_i) disable iff (!preset_n_i)
    (!up_i && down_i && count_o == '0) |=> (count_o == MAX_VAL));

endmodule

// File: tb/updn_counter_tb.sv
module updn_counter_tb_top;

  logic       clk_i = 1'b0;
  logic       preset_n_i = 1'b1;
  logic       up_i = 1'b0;
  logic       down_i = 1'b0;
  logic [5:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  updn_counter dut_i (
    .clk_i      (clk_i),
    .preset_n_i (preset_n_i),
    .up_i       (up_i),
    .down_i     (down_i),
    .count_o    (count_o)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive at falling edge, check 1 ns after the next rising edge
  task automatic step(input logic u, input logic d, input logic [5:0] exp, input string req);
    @(negedge clk_i);
    up_i = u;
    down_i = d;
    @(posedge clk_i);
    #1;
    chk(req, count_o, exp);
  endtask

  task automatic t_preset_async;
    #1 preset_n_i = 1'b0;
    #0.5;
    chk("R6 async preset", count_o, 6'd63);
    chk("R1 width all-ones", count_o, 6'b111111);
    up_i = 1'b1;
    down_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_i);
      #1;
      chk("R7 preset holds", count_o, 6'd63);
    end
    @(negedge clk_i);
    preset_n_i = 1'b1;
    up_i = 1'b0;
    down_i = 1'b1;
    @(posedge clk_i);
    #1;
    chk("R7 resume after release", count_o, 6'd62);
  endtask

  task automatic t_down_three;
    step(1'b0, 1'b1, 6'd61, "R3 down");
    step(1'b0, 1'b1, 6'd60, "R3 down");
  endtask

  task automatic t_up_three;
    step(1'b1, 1'b0, 6'd61, "R2 up");
    step(1'b1, 1'b0, 6'd62, "R2 up");
    step(1'b1, 1'b0, 6'd63, "R2 up");
  endtask

  task automatic t_hold;
    step(1'b1, 1'b0, 6'd0, "R8 wrap up");
    step(1'b1, 1'b0, 6'd1, "R2 up");
    step(1'b0, 1'b0, 6'd1, "R4 hold idle");
    step(1'b0, 1'b0, 6'd1, "R4 hold idle");
    step(1'b1, 1'b1, 6'd1, "R5 hold both");
    step(1'b1, 1'b1, 6'd1, "R5 hold both");
  endtask

  task automatic t_wrap_down;
    step(1'b0, 1'b1, 6'd0, "R3 down");
    step(1'b0, 1'b1, 6'd63, "R9 wrap down");
    step(1'b0, 1'b1, 6'd62, "R3 down");
  endtask

  task automatic t_preset_midrun;
    @(negedge clk_i);
    up_i = 1'b0;
    down_i = 1'b0;
    #0.5 preset_n_i = 1'b0;
    #0.5;
    chk("R6 async preset mid-run", count_o, 6'd63);
    @(negedge clk_i);
    preset_n_i = 1'b1;
    step(1'b1, 1'b0, 6'd0, "R8 wrap after preset");
  endtask

  initial begin
    t_preset_async;
    t_down_three;
    t_up_three;
    t_hold;
    t_wrap_down;
    t_preset_midrun;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule